// File: doc/BRIEF.md
# Card Configuration Register Block

This block holds the attribute-memory configuration space of a removable storage card that sits on a byte-wide host bus. The space has two regions. Addresses below a base set at elaboration read bytes from a small card-information ROM, and they read zero once the address runs past the ROM's length. At and above the base, four register slots are decoded at even offsets: an option register, a configuration-status register, a pin-replacement register and a reserved slot.

The block combines its own state with two inputs from neighbouring logic: the attached disk controller's interrupt line and the device-control byte held by the adjacent decode block. From these it drives the card interrupt output. A write that sets the option register's soft-reset bit clears the card-side state and sends a one-cycle reset request to the controller.

Reads are combinational from the address. Writes take effect on the clock edge where the write strobe is sampled high.

Top module: `cfgspace_regs`

## Requirements
- R1: After reset, the option register reads 0x00, and all mapping-mode outputs are 0. The status register reads 0x00 while the controller interrupt is low. The pin register reads 0x0C, and `host_rdy` and `soft_rst_req` are 0.
- R2: A read at address a < REG_BASE returns byte a of ROM_IMAGE (bits 8a+7..8a) when a < ROM_LEN. It returns 0x00 when ROM_LEN <= a < REG_BASE.
- R3: A write to offset 0x00 stores the data ANDed with 0xCF, and that value reads back. `map_mode` equals option bits 3..0, and `lvl_irq` equals option bit 6.
- R4: A write to offset 0x02 loads status bits 2, 4, 5 and 6 from the data and leaves bit 7 unchanged. When read, status bit 1 mirrors the controller interrupt input `ctl_irq`.
- R5: While device-control bit 1 is set, status bit 1 reads as 0 whatever `ctl_irq` is.
- R6: A status write whose bit 2 differs from the stored power-down bit (bit 2) sets the ready-change flag, which is pin bit 5 (the pin register then reads 0x2C). A status write that leaves bit 2 unchanged does not change the flag.
- R7: A write to offset 0x04 keeps pin bit 5 and loads pin bit 1 from data bit 1 onto `host_rdy`. The pin register reads back (bit 5) OR 0x0C.
- R8: Offset 0x06 and every other offset at or above the base except 0x00, 0x02 and 0x04 read 0x00. Writes to those offsets change no register.
- R9: `irq_out` is 1 exactly when `ctl_irq` is 0, device-control bits 1 and 2 are both 0, and option bit 7 is 0. It follows its inputs in the same cycle.
- R10: A write to offset 0x00 with data bit 7 set raises `soft_rst_req` for exactly the next cycle and clears the status and pin registers.
- R11: Writes at addresses below REG_BASE change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Attribute-space byte address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `bus_addr` |
| dc_ctrl | input | 8 | Device-control byte from the neighbouring decode block |
| ctl_irq | input | 1 | Interrupt-pending line from the attached controller |
| irq_out | output | 1 | Card interrupt output |
| soft_rst_req | output | 1 | One-cycle soft-reset request to the controller |
| map_mode | output | 4 | Address-mapping mode from option bits 3..0 |
| lvl_irq | output | 1 | Level-interrupt select, option bit 6 |
| host_rdy | output | 1 | Host-written ready bit, pin bit 1 |

## Verification
Assertions run on every cycle and check four things. Option writes are masked as stored. A power-down flip raises the ready-change flag, and the flag stays set until cleared. Status bit 7 holds across writes. The soft-reset pulse coincides with cleared status and pin state, and the interrupt stays low whenever a blocking bit is set. Some behaviours appear only in the bench's sweeps: read data against a model over the whole address space, the full 256-value sweeps of each writable register, writes to reserved, odd and below-base addresses having no effect, and the complete truth table of the interrupt output.

// File: rtl/cfgspace_pkg.sv
package cfgspace_pkg;

   localparam int unsigned BYTE_W = 8;

   // register offsets from the attribute base
   localparam int unsigned OFF_OPT  = 0;
   localparam int unsigned OFF_STAT = 2;
   localparam int unsigned OFF_PIN  = 4;
   localparam int unsigned OFF_RSV  = 6;

   // option register
   localparam logic [7:0] OPT_WMASK    = 8'hCF;
   localparam int unsigned OPT_SRST_B  = 7;
   localparam int unsigned OPT_LVL_B   = 6;
   localparam int unsigned MODE_W      = 4;

   // status register
   localparam logic [7:0] ST_HOLD_MASK = 8'h80;  // stored bits kept on write
   localparam logic [7:0] ST_LOAD_MASK = 8'h74;  // bits taken from write data
   localparam int unsigned ST_PEND_B   = 1;
   localparam int unsigned ST_PD_B     = 2;

   // pin-replacement register
   localparam logic [7:0] PIN_RD_CONST = 8'h0C;
   localparam int unsigned PIN_RCHG_B  = 5;
   localparam int unsigned PIN_HRDY_B  = 1;

   // device-control byte from the neighbour
   localparam logic [7:0] DC_IRQ_BLOCK = 8'h06;
   localparam int unsigned DC_IMASK_B  = 1;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_ROM,
      SEL_OPT,
      SEL_STAT,
      SEL_PIN,
      SEL_RSV
   } sel_e;

endpackage

// File: rtl/cfgspace_decode.sv
module cfgspace_decode
   import cfgspace_pkg::*;
#(
   parameter int unsigned ADDR_W = 10,
   parameter logic [ADDR_W-1:0] REG_BASE = 10'h200,
   parameter int unsigned ROM_LEN = 16,
   parameter int unsigned IDX_W = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   output sel_e              sel,
   output logic [IDX_W-1:0]  rom_idx,
   output logic              we_opt,
   output logic              we_stat,
   output logic              we_pin
);

   localparam logic [ADDR_W-1:0] O_OPT  = ADDR_W'(OFF_OPT);
   localparam logic [ADDR_W-1:0] O_STAT = ADDR_W'(OFF_STAT);
   localparam logic [ADDR_W-1:0] O_PIN  = ADDR_W'(OFF_PIN);
   localparam logic [ADDR_W-1:0] O_RSV  = ADDR_W'(OFF_RSV);
   localparam logic [ADDR_W:0]   ROM_END = (ADDR_W+1)'(ROM_LEN);

   logic [ADDR_W-1:0] off;
   logic              above;

   assign above   = (addr >= REG_BASE);
   assign off     = addr - REG_BASE;
   assign rom_idx = addr[IDX_W-1:0];

   always_comb begin
      sel = SEL_NONE;
      if (!above) begin
         if ({1'b0, addr} < ROM_END) sel = SEL_ROM;
      end else begin
         unique case (off)
            O_OPT:   sel = SEL_OPT;
            O_STAT:  sel = SEL_STAT;
            O_PIN:   sel = SEL_PIN;
            O_RSV:   sel = SEL_RSV;
            default: sel = SEL_NONE;
         endcase
      end
   end

   assign we_opt  = wr && (sel == SEL_OPT);
   assign we_stat = wr && (sel == SEL_STAT);
   assign we_pin  = wr && (sel == SEL_PIN);

endmodule

// File: rtl/cfgspace_rom.sv
module cfgspace_rom
   import cfgspace_pkg::*;
#(
   parameter int unsigned ROM_LEN = 16,
   parameter int unsigned IDX_W = 4,
   parameter logic [8*ROM_LEN-1:0] ROM_IMAGE = '0
) (
   input  logic [IDX_W-1:0]  idx,
   output logic [BYTE_W-1:0] data
);

   localparam int unsigned SLOTS = 1 << IDX_W;

   logic [BYTE_W-1:0] bytes [SLOTS];

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      if (g < ROM_LEN) begin : g_img
         assign bytes[g] = ROM_IMAGE[8*g +: 8];
      end else begin : g_pad
         assign bytes[g] = '0;
      end
   end

   assign data = bytes[idx];

endmodule

// File: rtl/cfgspace_opt.sv
module cfgspace_opt
   import cfgspace_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_opt,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] opt_q,
   output logic              clr,
   output logic              soft_rst_req
);

   assign clr = we_opt && wdata[OPT_SRST_B];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opt_q        <= '0;
         soft_rst_req <= 1'b0;
      end else begin
         soft_rst_req <= clr;
         if (we_opt) opt_q <= wdata & OPT_WMASK;
      end
   end

   p_opt_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
      we_opt |=> opt_q == ($past(wdata) & OPT_WMASK));

   p_srst_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_req |-> opt_q[OPT_SRST_B]);

endmodule

// File: rtl/cfgspace_stat.sv
module cfgspace_stat
   import cfgspace_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_stat,
   input  logic              we_pin,
   input  logic              clr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              pend_in,
   input  logic              pend_hide,
   output logic [BYTE_W-1:0] stat_view,
   output logic [BYTE_W-1:0] pin_view,
   output logic              host_rdy
);

   logic [BYTE_W-1:0] st_q;
   logic              rchg_q;
   logic              hrdy_q;
   logic              pd_flip;

   assign pd_flip = we_stat && (wdata[ST_PD_B] != st_q[ST_PD_B]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= '0;
         rchg_q <= 1'b0;
         hrdy_q <= 1'b0;
      end else if (clr) begin
         st_q   <= '0;
         rchg_q <= 1'b0;
         hrdy_q <= 1'b0;
      end else begin
         if (we_stat) st_q <= (st_q & ST_HOLD_MASK) | (wdata & ST_LOAD_MASK);
         if (pd_flip) rchg_q <= 1'b1;
         if (we_pin)  hrdy_q <= wdata[PIN_HRDY_B];
      end
   end

   always_comb begin
      stat_view = st_q;
      stat_view[ST_PEND_B] = pend_in && !pend_hide;
      pin_view = PIN_RD_CONST;
      pin_view[PIN_RCHG_B] = rchg_q;
   end

   assign host_rdy = hrdy_q;

   p_pd_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_flip && !clr) |=> pin_view[PIN_RCHG_B]);

   p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_view[PIN_RCHG_B] && !clr) |=> pin_view[PIN_RCHG_B]);

   p_chg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> stat_view[7] == $past(stat_view[7]));

   p_hide_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pend_hide |-> !stat_view[ST_PEND_B]);

endmodule

// File: rtl/cfgspace_regs.sv
module cfgspace_regs
   import cfgspace_pkg::*;
#(
   parameter int unsigned ADDR_W = 10,
   parameter logic [ADDR_W-1:0] REG_BASE = 10'h200,
   parameter int unsigned ROM_LEN = 16,
   parameter logic [8*ROM_LEN-1:0] ROM_IMAGE = {
      8'hFF, 8'h00, 8'h14, 8'h01, 8'hFF, 8'h00, 8'h1A, 8'h02,
      8'hFF, 8'h00, 8'h20, 8'h03, 8'hFF, 8'h00, 8'h15, 8'h01}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        rd_data,
   input  logic [7:0]        dc_ctrl,
   input  logic              ctl_irq,
   output logic              irq_out,
   output logic              soft_rst_req,
   output logic [3:0]        map_mode,
   output logic              lvl_irq,
   output logic              host_rdy
);

   localparam int unsigned IDX_W = (ROM_LEN > 1) ? $clog2(ROM_LEN) : 1;

   if (ROM_LEN < 1) begin : g_chk_rom_len
      $error("cfgspace_regs: ROM_LEN must be at least 1");
   end
   if (ROM_LEN > REG_BASE) begin : g_chk_rom_fit
      $error("cfgspace_regs: ROM must lie below REG_BASE");
   end
   if (IDX_W > ADDR_W) begin : g_chk_idx
      $error("cfgspace_regs: ROM index wider than address");
   end
   if ((REG_BASE + 7) >= (1 << ADDR_W)) begin : g_chk_base
      $error("cfgspace_regs: register window exceeds address space");
   end

   sel_e              sel;
   logic [IDX_W-1:0]  rom_idx;
   logic              we_opt, we_stat, we_pin;
   logic [7:0]        rom_data;
   logic [7:0]        opt_q;
   logic              clr;
   logic [7:0]        stat_view, pin_view;

   cfgspace_decode #(
      .ADDR_W(ADDR_W), .REG_BASE(REG_BASE), .ROM_LEN(ROM_LEN), .IDX_W(IDX_W)
   ) u_decode (
      .addr(bus_addr), .wr(bus_wr), .sel(sel), .rom_idx(rom_idx),
      .we_opt(we_opt), .we_stat(we_stat), .we_pin(we_pin)
   );

   cfgspace_rom #(
      .ROM_LEN(ROM_LEN), .IDX_W(IDX_W), .ROM_IMAGE(ROM_IMAGE)
   ) u_rom (
      .idx(rom_idx), .data(rom_data)
   );

   cfgspace_opt u_opt (
      .clk(clk), .rst_n(rst_n), .we_opt(we_opt), .wdata(bus_wdata),
      .opt_q(opt_q), .clr(clr), .soft_rst_req(soft_rst_req)
   );

   cfgspace_stat u_stat (
      .clk(clk), .rst_n(rst_n), .we_stat(we_stat), .we_pin(we_pin),
      .clr(clr), .wdata(bus_wdata), .pend_in(ctl_irq),
      .pend_hide(dc_ctrl[DC_IMASK_B]), .stat_view(stat_view),
      .pin_view(pin_view), .host_rdy(host_rdy)
   );

   always_comb begin
      unique case (sel)
         SEL_ROM:  rd_data = rom_data;
         SEL_OPT:  rd_data = opt_q;
         SEL_STAT: rd_data = stat_view;
         SEL_PIN:  rd_data = pin_view;
         default:  rd_data = '0;
      endcase
   end

   assign irq_out  = !ctl_irq && ((dc_ctrl & DC_IRQ_BLOCK) == 8'h00)
                     && !opt_q[OPT_SRST_B];
   assign map_mode = opt_q[MODE_W-1:0];
   assign lvl_irq  = opt_q[OPT_LVL_B];

   p_srst_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_req |-> ((stat_view & ST_LOAD_MASK) == 8'h00)
                       && (pin_view == PIN_RD_CONST) && !host_rdy);

   p_irq_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dc_ctrl[2] || ctl_irq || soft_rst_req) |-> !irq_out);

endmodule

// File: tb/cfgspace_regs_test.sv
`timescale 1ns/1ps
module cfgspace_regs_test;

   localparam int unsigned AW   = 8;
   localparam logic [7:0]  BASE = 8'h20;
   localparam int unsigned ROMN = 12;

   function automatic logic [7:0] img_byte(input int i);
      return 8'((i * 37 + 5) & 255);
   endfunction

   function automatic logic [8*ROMN-1:0] mk_img();
      logic [8*ROMN-1:0] v;
      for (int i = 0; i < ROMN; i++) v[8*i +: 8] = img_byte(i);
      return v;
   endfunction

   localparam logic [8*ROMN-1:0] IMG = mk_img();

   logic       clk = 0;
   logic       rst_n = 0;
   logic [7:0] bus_addr = 0;
   logic       bus_wr = 0;
   logic [7:0] bus_wdata = 0;
   logic [7:0] rd_data;
   logic [7:0] dc_ctrl = 0;
   logic       ctl_irq = 0;
   logic       irq_out, soft_rst_req, lvl_irq, host_rdy;
   logic [3:0] map_mode;

   always #2.5 clk = ~clk;

   cfgspace_regs #(.ADDR_W(AW), .REG_BASE(BASE), .ROM_LEN(ROMN), .ROM_IMAGE(IMG)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .rd_data(rd_data), .dc_ctrl(dc_ctrl),
      .ctl_irq(ctl_irq), .irq_out(irq_out), .soft_rst_req(soft_rst_req),
      .map_mode(map_mode), .lvl_irq(lvl_irq), .host_rdy(host_rdy)
   );

   int n_vec = 0;
   int n_bad = 0;

   // bench model of the register state
   logic [7:0] m_opt = 0;
   logic [7:0] m_st = 0;
   logic       m_rchg = 0;
   logic       m_hrdy = 0;

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_rd(input logic [7:0] a);
      logic [7:0] off;
      if (a < BASE) return (a < ROMN) ? img_byte(int'(a)) : 8'h00;
      off = a - BASE;
      case (off)
         8'h00: return m_opt;
         8'h02: return m_st | ((ctl_irq && !dc_ctrl[1]) ? 8'h02 : 8'h00);
         8'h04: return {2'b00, m_rchg, 5'b0} | 8'h0C;
         default: return 8'h00;
      endcase
   endfunction

   task automatic rd_chk(input string req, input logic [7:0] a);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(req, rd_data, exp_rd(a));
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      logic pulse;
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1;
      @(negedge clk);
      bus_wr = 0;
      pulse = 0;
      if (a >= BASE) begin
         case (8'(a - BASE))
            8'h00: begin
               m_opt = d & 8'hCF;
               if (d[7]) begin
                  m_st = 0; m_rchg = 0; m_hrdy = 0; pulse = 1;
               end
            end
            8'h02: begin
               if (m_st[2] != d[2]) m_rchg = 1;
               m_st = (m_st & 8'h80) | (d & 8'h74);
            end
            8'h04: m_hrdy = d[1];
            default: ;
         endcase
         if (a == BASE) chk("R10 pulse after option write", {7'b0, soft_rst_req}, {7'b0, pulse});
      end
      if (pulse) begin
         @(negedge clk);
         chk("R10 pulse lasts one cycle", {7'b0, soft_rst_req}, 8'h00);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1: reset state
      rd_chk("R1 option reset", BASE);
      rd_chk("R1 status reset", BASE + 8'h02);
      rd_chk("R1 pin reset", BASE + 8'h04);
      chk("R1 map_mode", {4'b0, map_mode}, 8'h00);
      chk("R1 host_rdy", {7'b0, host_rdy}, 8'h00);
      chk("R1 soft_rst_req", {7'b0, soft_rst_req}, 8'h00);

      // R2: whole region below the base
      for (int a = 0; a < int'(BASE); a++) rd_chk("R2 rom/zero region", 8'(a));

      // R3 / R10: option sweep
      for (int v = 0; v < 256; v++) begin
         if (v[7]) begin
            wr(BASE + 8'h02, 8'h54);
            wr(BASE + 8'h04, 8'h02);
         end
         wr(BASE, 8'(v));
         rd_chk("R3 option readback", BASE);
         chk("R3 map_mode", {4'b0, map_mode}, 8'(v & 15));
         chk("R3 lvl_irq", {7'b0, lvl_irq}, {7'b0, v[6]});
         if (v[7]) begin
            rd_chk("R10 status cleared", BASE + 8'h02);
            rd_chk("R10 pin cleared", BASE + 8'h04);
            chk("R10 host_rdy cleared", {7'b0, host_rdy}, 8'h00);
         end
      end
      wr(BASE, 8'h00);

      // R6: no flip leaves flag clear, a flip sets it
      wr(BASE + 8'h02, 8'hF0);
      rd_chk("R6 no flip keeps flag clear", BASE + 8'h04);
      wr(BASE + 8'h02, 8'h04);
      rd_chk("R6 flip sets flag", BASE + 8'h04);
      wr(BASE + 8'h02, 8'h04);
      rd_chk("R6 flag stays set", BASE + 8'h04);

      // R4 / R5: status sweep with pending and mask combinations
      for (int v = 0; v < 256; v++) begin
         @(negedge clk);
         ctl_irq = v[0] ^ v[3];
         dc_ctrl = v[1] ? 8'h02 : 8'h00;
         wr(BASE + 8'h02, 8'(v));
         rd_chk(dc_ctrl[1] ? "R5 status masked pend" : "R4 status readback", BASE + 8'h02);
         rd_chk("R6 pin flag after status write", BASE + 8'h04);
      end
      dc_ctrl = 0; ctl_irq = 0;

      // R7: pin writes
      for (int v = 0; v < 256; v++) begin
         wr(BASE + 8'h04, 8'(v));
         rd_chk("R7 pin readback", BASE + 8'h04);
         chk("R7 host_rdy", {7'b0, host_rdy}, {7'b0, v[1]});
      end

      // R8: reserved and odd offsets
      wr(BASE, 8'h4B);
      wr(BASE + 8'h02, 8'h30);
      wr(BASE + 8'h04, 8'h02);
      for (int o = 1; o < 16; o++) begin
         if (o != 2 && o != 4) begin
            wr(BASE + 8'(o), 8'hFF);
            rd_chk("R8 offset reads zero", BASE + 8'(o));
         end
      end
      rd_chk("R8 option untouched", BASE);
      rd_chk("R8 status untouched", BASE + 8'h02);
      rd_chk("R8 pin untouched", BASE + 8'h04);
      chk("R8 host_rdy untouched", {7'b0, host_rdy}, 8'h01);

      // R11: writes below base
      for (int a = 0; a < int'(BASE); a += 3) wr(8'(a), 8'hFF);
      rd_chk("R11 option untouched", BASE);
      rd_chk("R11 status untouched", BASE + 8'h02);
      rd_chk("R11 pin untouched", BASE + 8'h04);
      rd_chk("R11 rom byte intact", 8'h05);

      // R9: interrupt truth table, same-cycle response
      for (int c = 0; c < 32; c++) begin
         wr(BASE, c[3] ? 8'h80 : 8'h00);
         @(negedge clk);
         ctl_irq = c[0];
         dc_ctrl = (c[4] ? 8'hF9 : 8'h00) | (c[1] ? 8'h02 : 8'h00) | (c[2] ? 8'h04 : 8'h00);
         #1;
         chk("R9 irq_out", {7'b0, irq_out},
             {7'b0, !c[0] && !c[1] && !c[2] && !c[3]});
      end
      dc_ctrl = 0; ctl_irq = 0;
      wr(BASE, 8'h00);

      // R2 / R8: final sweep of the full address space
      wr(BASE + 8'h02, 8'hD4);
      for (int a = 0; a < 256; a++) rd_chk("R2 R8 full map sweep", 8'(a));

      finish_run();
   end

endmodule